// File: doc/BRIEF.md
# Multi-Queue Instruction Dispatcher

This block takes an in-order stream of instruction words, one per cycle. It decodes each word and either retires it on the spot or places it into one of five independent issue FIFOs. Scalar words finish inside the dispatcher and are reported on a one-cycle completion strobe. Vector and matrix words each go to their own queue. Data-movement words go to one of three movement queues, and the queue is picked from the word's source and destination memory levels. A movement with no valid path is flagged as illegal and thrown away.

Every queue drains in order to its own execution-unit port using a valid/ready handshake. A queue that is blocked holds back only its own traffic, and the other queues keep draining. When the queue an instruction needs is full, the dispatcher lowers its input ready. The stalled word stays at the head of the stream, so nothing behind it can overtake it.

Top module: `instr_dispatch`

## Requirements
- R1: After reset, every queue output valid is low, the scalar strobe and the illegal strobe are low, and `in_ready` is high.
- R2: A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. An accepted word with class field `in_word[15:13]` = 0 (scalar) raises `scalar_done` for exactly one cycle after acceptance, with `scalar_word` equal to that word. The word enters no queue, and a scalar word never sees `in_ready` low.
- R3: Class 1 (vector) goes to queue 0. Class 2 (matrix) goes to queue 1.
- R4: Class 3 (movement) takes its source level from `in_word[12:10]` and its destination level from `in_word[9:7]`. Level codes are 0=L1, 1=L0A, 2=L0B, 3=unified buffer, 4=external memory, 5=special register. Movement-1 (queue 2) takes the paths L1 to {L0A, L0B, unified buffer} and special register to {L0A, L0B}.
- R5: Movement-2 (queue 3) takes the paths external memory to {L1, L0A, L0B, unified buffer}.
- R6: Movement-3 (queue 4) takes the path unified buffer to external memory.
- R7: Two kinds of accepted word are illegal: a movement whose source/destination pair matches none of R4 to R6, and any class value 4 to 7. An illegal word pulses `illegal_flag` for one cycle after acceptance, enters no queue, and does not also pulse `scalar_done`.
- R8: Each queue holds 4 entries. If the word on the input targets a full queue, `in_ready` is low and the word is not accepted. It is accepted on the first edge where that queue has room.
- R9: Each queue presents its oldest entry on its slice `q_data[16*i +: 16]` while `q_valid[i]` is high. It removes the entry on an edge with `q_ready[i]` high, so words leave each queue in dispatch order. A head that is not taken stays unchanged.
- R10: The queues drain independently. A queue with `q_ready` low does not stop other queues from issuing, and it does not stop words bound for other queues from being accepted.
- R11: A word accepted into an empty queue appears at that queue's head in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word offered |
| in_word | input | 16 | Instruction word: class, source level, destination level, operand |
| in_ready | output | 1 | Dispatcher can take the offered word this cycle |
| q_valid | output | 5 | Per-queue head valid (0 vector, 1 matrix, 2..4 movement-1..3) |
| q_data | output | 80 | Per-queue head word, 16 bits per queue |
| q_ready | input | 5 | Per-queue execution-unit ready |
| scalar_done | output | 1 | One-cycle strobe for a retired scalar word |
| scalar_word | output | 16 | The scalar word just retired |
| illegal_flag | output | 1 | One-cycle strobe for a dropped illegal word |

## Verification
The bench sweeps all 64 source/destination pairs and all out-of-range class values. A decoder with a swapped or missing path would send a word to the wrong queue, drop a legal word, or enqueue an illegal one. It fills a queue while its unit is stalled. This shows whether the dispatcher overruns the FIFO, accepts the blocked word early, or keeps holding it after space frees up. While one queue is blocked it drains a second queue, to catch a design that stalls globally. Long random runs with random per-queue ready compare every head word against an in-order reference, to catch reordering or lost and duplicated entries when pushes and pops land in the same cycle.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

  localparam int NQ    = 5;
  localparam int CLS_W = 3;
  localparam int LVL_W = 3;
  localparam int HDR_W = CLS_W + 2 * LVL_W;

  localparam logic [CLS_W-1:0] CLS_SCALAR = 3'd0;
  localparam logic [CLS_W-1:0] CLS_VECTOR = 3'd1;
  localparam logic [CLS_W-1:0] CLS_MATRIX = 3'd2;
  localparam logic [CLS_W-1:0] CLS_MOVE   = 3'd3;

  localparam logic [LVL_W-1:0] LV_L1  = 3'd0;
  localparam logic [LVL_W-1:0] LV_L0A = 3'd1;
  localparam logic [LVL_W-1:0] LV_L0B = 3'd2;
  localparam logic [LVL_W-1:0] LV_UB  = 3'd3;
  localparam logic [LVL_W-1:0] LV_EXT = 3'd4;
  localparam logic [LVL_W-1:0] LV_SPR = 3'd5;

  localparam int Q_VEC = 0;
  localparam int Q_MAT = 1;
  localparam int Q_MV1 = 2;
  localparam int Q_MV2 = 3;
  localparam int Q_MV3 = 4;

  typedef struct packed {
    logic          scalar;
    logic          illegal;
    logic [NQ-1:0] qsel;
  } route_t;

endpackage

// File: rtl/dispatch_decode.sv
module dispatch_decode
  import dispatch_pkg::*;
(
  input  logic [HDR_W-1:0] hdr,
  output route_t           route
);

  localparam int CLS_LSB = HDR_W - CLS_W;
  localparam int SRC_LSB = CLS_LSB - LVL_W;
  localparam int DST_LSB = SRC_LSB - LVL_W;

  logic [CLS_W-1:0] cls;
  logic [LVL_W-1:0] src;
  logic [LVL_W-1:0] dst;
  logic             dst_l0;
  logic             dst_l0_ub;
  logic             to_mv1;
  logic             to_mv2;
  logic             to_mv3;

  assign cls = hdr[CLS_LSB +: CLS_W];
  assign src = hdr[SRC_LSB +: LVL_W];
  assign dst = hdr[DST_LSB +: LVL_W];

  assign dst_l0    = (dst == LV_L0A) || (dst == LV_L0B);
  assign dst_l0_ub = dst_l0 || (dst == LV_UB);

  // path rules for the three movement queues
  assign to_mv1 = ((src == LV_L1) && dst_l0_ub) || ((src == LV_SPR) && dst_l0);
  assign to_mv2 = (src == LV_EXT) && (dst_l0_ub || (dst == LV_L1));
  assign to_mv3 = (src == LV_UB) && (dst == LV_EXT);

  always_comb begin
    route = '0;
    case (cls)
      CLS_SCALAR: route.scalar = 1'b1;
      CLS_VECTOR: route.qsel[Q_VEC] = 1'b1;
      CLS_MATRIX: route.qsel[Q_MAT] = 1'b1;
      CLS_MOVE: begin
        if (to_mv1)      route.qsel[Q_MV1] = 1'b1;
        else if (to_mv2) route.qsel[Q_MV2] = 1'b1;
        else if (to_mv3) route.qsel[Q_MV3] = 1'b1;
        else             route.illegal     = 1'b1;
      end
      default:    route.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/dispatch_fifo.sv
module dispatch_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic          pop;

  assign pop       = out_valid && out_ready;
  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

endmodule

// File: rtl/instr_dispatch.sv
module instr_dispatch
  import dispatch_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int QDEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [WORD_W-1:0]    in_word,
  output logic                 in_ready,
  output logic [NQ-1:0]        q_valid,
  output logic [NQ*WORD_W-1:0] q_data,
  input  logic [NQ-1:0]        q_ready,
  output logic                 scalar_done,
  output logic [WORD_W-1:0]    scalar_word,
  output logic                 illegal_flag
);

  route_t        route;
  logic [NQ-1:0] q_full;
  logic [NQ-1:0] q_push;
  logic          accept;

  dispatch_decode u_decode (
    .hdr   (in_word[WORD_W-1 -: HDR_W]),
    .route (route)
  );

  // only the selected queue can hold the stream back
  assign in_ready = route.scalar || route.illegal || ((route.qsel & q_full) == '0);
  assign accept   = in_valid && in_ready;
  assign q_push   = accept ? route.qsel : '0;

  generate
    for (genvar i = 0; i < NQ; i++) begin : g_q
      dispatch_fifo #(
        .W     (WORD_W),
        .DEPTH (QDEPTH)
      ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push[i]),
        .din       (in_word),
        .full      (q_full[i]),
        .out_valid (q_valid[i]),
        .out_data  (q_data[i*WORD_W +: WORD_W]),
        .out_ready (q_ready[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scalar_done  <= 1'b0;
      scalar_word  <= '0;
      illegal_flag <= 1'b0;
    end else begin
      scalar_done  <= accept && route.scalar;
      illegal_flag <= accept && route.illegal;
      if (accept && route.scalar) scalar_word <= in_word;
    end
  end

endmodule

// File: rtl/instr_dispatch_chk.sv
module instr_dispatch_chk #(
  parameter int W  = 16,
  parameter int NQ = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    in_cls,
  input logic          in_ready,
  input logic [NQ-1:0] q_valid,
  input logic [NQ*W-1:0] q_data,
  input logic [NQ-1:0] q_ready,
  input logic          scalar_done,
  input logic          illegal_flag
);

  AST_SCALAR_NEXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_cls == 3'd0) |=> scalar_done); // R2

  AST_SCALAR_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (in_cls == 3'd0) |-> in_ready); // R2

  AST_ILLEGAL_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    illegal_flag |-> $past(in_valid && in_ready)); // R7

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    !(scalar_done && illegal_flag)); // R7

  AST_STALL_NEEDS_BACKLOG: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (q_valid != '0)); // R8

  generate
    for (genvar i = 0; i < NQ; i++) begin : g_hold
      AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (q_valid[i] && !q_ready[i]) |=> (q_valid[i] && $stable(q_data[i*W +: W]))); // R9
    end
  endgenerate

endmodule

bind instr_dispatch instr_dispatch_chk #(
  .W  (WORD_W),
  .NQ (dispatch_pkg::NQ)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_cls       (in_word[WORD_W-1 -: 3]),
  .in_ready     (in_ready),
  .q_valid      (q_valid),
  .q_data       (q_data),
  .q_ready      (q_ready),
  .scalar_done  (scalar_done),
  .illegal_flag (illegal_flag)
);

// File: tb/instr_dispatch_bench.sv
`timescale 1ns/1ps
module instr_dispatch_bench;

  localparam int W  = 16;
  localparam int NQ = 5;
  localparam int DEP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic            in_valid = 1'b0;
  logic [W-1:0]    in_word  = '0;
  logic            in_ready;
  logic [NQ-1:0]   q_valid;
  logic [NQ*W-1:0] q_data;
  logic [NQ-1:0]   q_ready = '0;
  logic            scalar_done;
  logic [W-1:0]    scalar_word;
  logic            illegal_flag;

  instr_dispatch u_instr_dispatch (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .q_valid(q_valid), .q_data(q_data),
    .q_ready(q_ready), .scalar_done(scalar_done),
    .scalar_word(scalar_word), .illegal_flag(illegal_flag)
  );

  int checks = 0;
  int fails  = 0;
  bit stop_cmp = 1'b0;

  logic [W-1:0] mq [NQ][$];
  logic         exp_sd  = 1'b0;
  logic         exp_ill = 1'b0;
  logic [W-1:0] exp_sw  = '0;
  int pushed [NQ];
  int popped [NQ];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // route: 0..4 queue, 5 scalar, 6 illegal
  function automatic int route(input logic [W-1:0] w);
    int c = int'(w[15:13]);
    int s = int'(w[12:10]);
    int d = int'(w[9:7]);
    if (c == 0) return 5;
    if (c == 1) return 0;
    if (c == 2) return 1;
    if (c != 3) return 6;
    if (s == 0 && d >= 1 && d <= 3) return 2;
    if (s == 5 && (d == 1 || d == 2)) return 2;
    if (s == 4 && d <= 3) return 3;
    if (s == 3 && d == 4) return 4;
    return 6;
  endfunction

  function automatic logic [W-1:0] mk(input int c, input int s, input int d, input int op);
    return {3'(c), 3'(s), 3'(d), 7'(op)};
  endfunction

  // reference model, advances on each edge
  always @(posedge clk) begin
    int r;
    bit acc;
    if (rst) begin
      for (int q = 0; q < NQ; q++) mq[q].delete();
      exp_sd  = 1'b0;
      exp_ill = 1'b0;
      exp_sw  = '0;
    end else begin
      r   = route(in_word);
      acc = in_valid && (r >= NQ || mq[r].size() < DEP);
      for (int q = 0; q < NQ; q++)
        if (q_ready[q] && mq[q].size() > 0) begin
          void'(mq[q].pop_front());
          popped[q]++;
        end
      if (acc && r < NQ) begin
        mq[r].push_back(in_word);
        pushed[r]++;
      end
      exp_sd  = acc && (r == 5);
      exp_ill = acc && (r == 6);
      if (acc && r == 5) exp_sw = in_word;
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    int r;
    bit rdy;
    if (!rst && !stop_cmp) begin
      r   = route(in_word);
      rdy = (r >= NQ) || (mq[r].size() < DEP);
      chk(in_ready == rdy, "R8 in_ready", in_ready, rdy);
      chk(scalar_done == exp_sd, "R2 scalar_done", scalar_done, exp_sd);
      if (exp_sd) chk(scalar_word == exp_sw, "R2 scalar_word", scalar_word, exp_sw);
      chk(illegal_flag == exp_ill, "R7 illegal_flag", illegal_flag, exp_ill);
      for (int q = 0; q < NQ; q++) begin
        string tg;
        tg = (q < 2) ? "R3" : (q == 2) ? "R4" : (q == 3) ? "R5" : "R6";
        chk(q_valid[q] == (mq[q].size() > 0), {tg, " R11 q_valid"}, q_valid[q], mq[q].size() > 0);
        if (mq[q].size() > 0)
          chk(q_data[q*W +: W] == mq[q][0], {tg, " R9 q_data"}, q_data[q*W +: W], mq[q][0]);
      end
    end
  end

  task automatic send(input logic [W-1:0] w);
    bit ok;
    in_valid = 1'b1;
    in_word  = w;
    do begin
      @(negedge clk);
      ok = in_ready;
      @(posedge clk);
    end while (!ok);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic stimulus();
    int p1;
    // R1 reset state
    @(negedge clk);
    chk(q_valid == '0, "R1 q_valid", q_valid, 0);
    chk(!scalar_done && !illegal_flag, "R1 strobes", {scalar_done, illegal_flag}, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    @(posedge clk); #1;

    // R10: vector queue full and blocked, matrix queue drains
    q_ready = '0;
    send(mk(0, 0, 0, 1));
    send(mk(2, 0, 0, 2));
    send(mk(2, 0, 0, 3));
    for (int i = 0; i < DEP; i++) send(mk(1, 0, 0, 10 + i));
    p1 = popped[1];
    q_ready = 5'b00010;
    idle(4);
    @(negedge clk);
    chk(popped[1] - p1 == 2, "R10 matrix drained", popped[1] - p1, 2);
    chk(q_valid[0] == 1'b1, "R10 vector still held", q_valid[0], 1);
    @(posedge clk); #1;

    // R8: fifth vector stalls, scalar behind it must wait
    fork
      begin
        send(mk(1, 0, 0, 20));
        send(mk(0, 0, 0, 21));
      end
      begin
        repeat (3) begin
          @(negedge clk);
          chk(in_ready == 1'b0, "R8 stall on full", in_ready, 0);
          chk(!scalar_done, "R8 no bypass", scalar_done, 0);
        end
        @(posedge clk); #1;
        q_ready = 5'b00001;
      end
    join
    q_ready = '1;
    idle(8);

    // R4 R5 R6 R7: every movement path
    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 8; d++)
        send(mk(3, s, d, s * 8 + d));
    for (int c = 4; c < 8; c++) send(mk(c, 0, 1, c));   // R7 bad class
    idle(6);

    // R9 ordering under backpressure on movement-2
    q_ready = '0;
    for (int i = 0; i < DEP; i++) send(mk(3, 4, i, 40 + i));
    send(mk(3, 3, 4, 50));
    idle(2);
    q_ready = 5'b01000;
    idle(6);
    q_ready = '1;
    idle(4);

    // random traffic with random per-queue ready
    for (int n = 0; n < 2500; n++) begin
      int c;
      c = $urandom_range(0, 9);
      if (c > 7) c = 3;
      q_ready = NQ'($urandom_range(0, 31));
      send(mk(c, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 127)));
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    q_ready = '1;
    idle(12);
    @(negedge clk);
    for (int q = 0; q < NQ; q++)
      chk(pushed[q] == popped[q] && pushed[q] > 0, "R9 R10 all issued", popped[q], pushed[q]);
    chk(q_valid == '0, "R9 queues empty", q_valid, 0);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    for (int q = 0; q < NQ; q++) begin
      pushed[q] = 0;
      popped[q] = 0;
    end
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    fork
      stimulus();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    stop_cmp = 1'b1;
    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule